// File: doc/BRIEF.md
# Locked Configuration Index/Data Port

This block is the configuration front end of a peripheral controller on a byte-wide I/O bus. It answers at a pair of adjacent port addresses: an index port and, one address above, a data port. The pair sits at one of two base addresses picked by a strap pin. After reset the port is locked. It opens only when a fixed four-byte key is written to the index port, and the last key byte depends on which base is strapped. Once open, an index write picks a configuration register, and data-port reads and writes reach it. Writing the leave-configuration command to the lock register closes the port again.

The register file holds a chip identification word, a revision byte and a logical-device selector. It also holds the registers of the flash-interface device: a 16-bit base address for the flash command port and a steering bit that picks one of two flash devices. The block drives the flash base and the steering bit out as ports, together with a flag that says whether the programmed base is usable.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset the port is locked, `flash_sel` is 0 and `flash_base` is 0x0290 with `flash_base_valid` high.
- R2: With `strap_alt` = 0 the index port is 0x002E, and with `strap_alt` = 1 it is 0x004E. The data port is the index port plus one. Writes to the other base have no effect.
- R3: The port unlocks on four consecutive index-port writes 0x87, 0x01, 0x55, K, where K = 0x55 at base 0x002E and K = 0xAA at base 0x004E. Any other final byte leaves it locked.
- R4: A wrong byte inside the key sends the matcher back to idle. If that wrong byte is 0x87, it counts as the first key byte.
- R5: While locked, `io_rdata` is 0xFF and data-port writes change nothing. While unlocked, `io_rdata` is 0xFF for any address other than the data port.
- R6: Register 0x20 reads 0x87, register 0x21 reads 0xC3 and register 0x22 reads 0x04.
- R7: Register 0x07 is the read/write logical-device select. Registers 0x64, 0x65 and 0xEF belong to device 7. Under any other device they read 0x00 and ignore writes.
- R8: In device 7, register 0x64 holds the high byte and register 0x65 the low byte of `flash_base`. Both read back.
- R9: `flash_base_valid` is high exactly when `flash_base` is nonzero, below 0x1000 and a multiple of 8.
- R10: In device 7, bit 0 of register 0xEF drives `flash_sel`. The other bits of that register read 0.
- R11: A data write to register 0x02 with bit 1 set relocks the port, and a new full key is then needed. A write there with bit 1 clear leaves the port open.
- R12: Any configuration register not listed above reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strap_alt | input | 1 | Base select: 0 for 0x002E, 1 for 0x004E |
| io_addr | input | 16 | I/O address |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data of the data port (combinational) |
| cfg_active | output | 1 | High while the port is unlocked |
| flash_base | output | 16 | Flash command-port base address |
| flash_base_valid | output | 1 | The flash base obeys the placement rule |
| flash_sel | output | 1 | Flash device steering |

## Verification
Every write takes effect at the clock edge that samples its strobe. This includes the key byte that unlocks and the lock-register write that relocks. So `cfg_active`, `flash_base`, `flash_base_valid` and `flash_sel` are checked in the cycle after that edge. Reads have no register in the path: `io_rdata` follows the address and the stored state in the same cycle. The bench drives inputs on the falling edge and samples one time unit later, well before the next rising edge. Each write strobe lasts exactly one cycle, so one bus write counts as exactly one key byte.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
  localparam logic [7:0] KEY_FIRST  = 8'h87;
  localparam logic [7:0] KEY_SECOND = 8'h01;
  localparam logic [7:0] KEY_THIRD  = 8'h55;
  localparam logic [7:0] KEY_LAST_A = 8'h55;
  localparam logic [7:0] KEY_LAST_B = 8'hAA;

  localparam logic [7:0] REG_LOCK  = 8'h02;
  localparam logic [7:0] REG_LDN   = 8'h07;
  localparam logic [7:0] REG_ID_HI = 8'h20;
  localparam logic [7:0] REG_ID_LO = 8'h21;
  localparam logic [7:0] REG_REV   = 8'h22;
  localparam logic [7:0] REG_FB_HI = 8'h64;
  localparam logic [7:0] REG_FB_LO = 8'h65;
  localparam logic [7:0] REG_STEER = 8'hEF;

  // Expected key byte at a given position; the final one depends on the strap.
  function automatic logic [7:0] key_byte(input logic [1:0] step, input logic alt);
    case (step)
      2'd0:    return KEY_FIRST;
      2'd1:    return KEY_SECOND;
      2'd2:    return KEY_THIRD;
      default: return alt ? KEY_LAST_B : KEY_LAST_A;
    endcase
  endfunction

  // Flash base placement rule: nonzero, below 4 KiB, 8-byte aligned.
  function automatic logic base_ok(input logic [15:0] b);
    return (b != 16'h0000) && (b[15:12] == 4'h0) && (b[2:0] == 3'b000);
  endfunction
endpackage

// File: rtl/sio_key_matcher.sv
module sio_key_matcher
  import sio_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       alt,
  input  logic       idx_wr,
  input  logic [7:0] wdata,
  input  logic       relock,
  output logic       unlocked,
  output logic       unlock_pulse
);
  logic [1:0] step;
  logic       hit;

  assign hit          = (wdata == key_byte(step, alt));
  assign unlock_pulse = idx_wr && !unlocked && hit && (step == 2'd3);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step     <= 2'd0;
      unlocked <= 1'b0;
    end else if (relock) begin
      step     <= 2'd0;
      unlocked <= 1'b0;
    end else if (idx_wr && !unlocked) begin
      if (hit) begin
        if (step == 2'd3) begin
          unlocked <= 1'b1;
          step     <= 2'd0;
        end else begin
          step <= step + 2'd1;
        end
      end else begin
        step <= (wdata == KEY_FIRST) ? 2'd1 : 2'd0;
      end
    end
  end
endmodule

// File: rtl/sio_reg_file.sv
module sio_reg_file
  import sio_cfg_pkg::*;
#(
  parameter logic [15:0] CHIP_ID   = 16'h87C3,
  parameter logic [7:0]  CHIP_REV  = 8'h04,
  parameter logic [7:0]  FLASH_LDN = 8'h07,
  parameter logic [15:0] BASE_RST  = 16'h0290
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        active,
  input  logic        idx_wr,
  input  logic        dat_wr,
  input  logic [7:0]  wdata,
  output logic [7:0]  rd_val,
  output logic        relock,
  output logic [15:0] flash_base,
  output logic        flash_sel
);
  logic [7:0] index_q;
  logic [7:0] ldn_q;
  logic [7:0] fb_hi_q, fb_lo_q;
  logic       sel_q;
  logic       dev_hit;
  logic       cfg_wr;

  assign dev_hit = (ldn_q == FLASH_LDN);
  assign cfg_wr  = active && dat_wr;
  assign relock  = cfg_wr && (index_q == REG_LOCK) && wdata[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      index_q <= 8'h00;
      ldn_q   <= 8'h00;
      fb_hi_q <= BASE_RST[15:8];
      fb_lo_q <= BASE_RST[7:0];
      sel_q   <= 1'b0;
    end else begin
      if (relock)
        index_q <= 8'h00;
      else if (active && idx_wr)
        index_q <= wdata;
      if (cfg_wr) begin
        case (index_q)
          REG_LDN:   ldn_q <= wdata;
          REG_FB_HI: if (dev_hit) fb_hi_q <= wdata;
          REG_FB_LO: if (dev_hit) fb_lo_q <= wdata;
          REG_STEER: if (dev_hit) sel_q <= wdata[0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rd_val = 8'h00;
    case (index_q)
      REG_ID_HI: rd_val = CHIP_ID[15:8];
      REG_ID_LO: rd_val = CHIP_ID[7:0];
      REG_REV:   rd_val = CHIP_REV;
      REG_LDN:   rd_val = ldn_q;
      REG_FB_HI: if (dev_hit) rd_val = fb_hi_q;
      REG_FB_LO: if (dev_hit) rd_val = fb_lo_q;
      REG_STEER: if (dev_hit) rd_val = {7'b0, sel_q};
      default:   rd_val = 8'h00;
    endcase
  end

  assign flash_base = {fb_hi_q, fb_lo_q};
  assign flash_sel  = sel_q;
endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
  import sio_cfg_pkg::*;
#(
  parameter logic [15:0] BASE_A    = 16'h002E,
  parameter logic [15:0] BASE_B    = 16'h004E,
  parameter logic [15:0] CHIP_ID   = 16'h87C3,
  parameter logic [7:0]  CHIP_REV  = 8'h04,
  parameter logic [7:0]  FLASH_LDN = 8'h07,
  parameter logic [15:0] BASE_RST  = 16'h0290
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        strap_alt,
  input  logic [15:0] io_addr,
  input  logic        io_wr,
  input  logic [7:0]  io_wdata,
  output logic [7:0]  io_rdata,
  output logic        cfg_active,
  output logic [15:0] flash_base,
  output logic        flash_base_valid,
  output logic        flash_sel
);
  logic [15:0] idx_addr;
  logic        idx_wr, dat_sel, dat_wr;
  logic [7:0]  rd_val;
  logic        unlock_pulse, relock_pulse;

  assign idx_addr = strap_alt ? BASE_B : BASE_A;
  assign idx_wr   = io_wr && (io_addr == idx_addr);
  assign dat_sel  = (io_addr == idx_addr + 16'd1);
  assign dat_wr   = io_wr && dat_sel;

  sio_key_matcher u_key (
    .clk(clk), .rst_n(rst_n), .alt(strap_alt), .idx_wr(idx_wr),
    .wdata(io_wdata), .relock(relock_pulse),
    .unlocked(cfg_active), .unlock_pulse(unlock_pulse)
  );

  sio_reg_file #(
    .CHIP_ID(CHIP_ID), .CHIP_REV(CHIP_REV),
    .FLASH_LDN(FLASH_LDN), .BASE_RST(BASE_RST)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .active(cfg_active), .idx_wr(idx_wr),
    .dat_wr(dat_wr), .wdata(io_wdata), .rd_val(rd_val),
    .relock(relock_pulse), .flash_base(flash_base), .flash_sel(flash_sel)
  );

  assign io_rdata         = (cfg_active && dat_sel) ? rd_val : 8'hFF;
  assign flash_base_valid = base_ok(flash_base);
endmodule

// File: rtl/sio_cfg_port_chk.sv
module sio_cfg_port_chk #(
  parameter logic [15:0] CHK_BASE_A = 16'h002E,
  parameter logic [15:0] CHK_BASE_B = 16'h004E
) (
  input logic        clk,
  input logic        rst_n,
  input logic        strap_alt,
  input logic [15:0] io_addr,
  input logic        io_wr,
  input logic [7:0]  io_wdata,
  input logic [7:0]  io_rdata,
  input logic        cfg_active,
  input logic [15:0] flash_base,
  input logic        flash_base_valid,
  input logic        flash_sel,
  input logic        unlock_pulse,
  input logic        relock_pulse
);
  logic [15:0] chk_idx;
  assign chk_idx = strap_alt ? CHK_BASE_B : CHK_BASE_A;

  // R5
  locked_reads_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_active |-> io_rdata == 8'hFF);

  // R3
  unlock_from_index_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_active) |-> $past(io_wr && io_addr == chk_idx));

  // R3
  unlock_pulse_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unlock_pulse |=> cfg_active);

  // R11
  relock_from_data_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cfg_active) |-> $past(io_wr && io_addr == chk_idx + 16'd1 && io_wdata[1]));

  // R4
  pulses_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({unlock_pulse, relock_pulse}));

  // R10
  steer_frozen_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_active |=> $stable(flash_sel));

  // R9
  valid_base_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flash_base_valid |-> (flash_base[2:0] == 3'b000 && flash_base[15:12] == 4'h0));
endmodule

bind sio_cfg_port sio_cfg_port_chk u_chk (.*);

// File: tb/sio_cfg_port_test.sv
module sio_cfg_port_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strap_alt = 1'b0;
  logic [15:0] io_addr = 16'h0000;
  logic        io_wr = 1'b0;
  logic [7:0]  io_wdata = 8'h00;
  logic [7:0]  io_rdata;
  logic        cfg_active;
  logic [15:0] flash_base;
  logic        flash_base_valid;
  logic        flash_sel;

  int checks = 0;
  int errors = 0;
  logic [15:0] ip;

  sio_cfg_port uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 50000);
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
    #1;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    io_addr = a;
    #1 d = io_rdata;
  endtask

  task automatic key(input logic [7:0] last);
    wr(ip, 8'h87); wr(ip, 8'h01); wr(ip, 8'h55); wr(ip, last);
  endtask

  task automatic cfg_rd(input logic [7:0] r, output logic [7:0] d);
    wr(ip, r); rd(ip + 16'd1, d);
  endtask

  task automatic cfg_wr(input logic [7:0] r, input logic [7:0] d);
    wr(ip, r); wr(ip + 16'd1, d);
  endtask

  task automatic do_reset(input logic alt);
    @(negedge clk);
    rst_n = 1'b0; strap_alt = alt; ip = alt ? 16'h004E : 16'h002E;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(16'h002F, d);
    chk("R1 locked rdata", d, 8'hFF);
    chk("R1 active", cfg_active, 0);
    chk("R1 sel", flash_sel, 0);
    chk("R1 base", flash_base, 16'h0290);
    chk("R1 valid", flash_base_valid, 1);
  endtask

  task automatic t_locked();
    logic [7:0] d;
    wr(16'h002E, 8'h07); wr(16'h002F, 8'h07);
    wr(16'h002E, 8'h64); wr(16'h002F, 8'h00);
    rd(16'h002F, d);
    chk("R5 locked read", d, 8'hFF);
    chk("R5 base kept", flash_base, 16'h0290);
    key(8'hAA);
    chk("R3 wrong final byte stays locked", cfg_active, 0);
    wr(16'h004E, 8'h87); wr(16'h004E, 8'h01); wr(16'h004E, 8'h55); wr(16'h004E, 8'h55);
    chk("R2 other base ignored", cfg_active, 0);
  endtask

  task automatic t_restart();
    wr(ip, 8'h87); wr(ip, 8'h01); wr(ip, 8'h87);
    wr(ip, 8'h01); wr(ip, 8'h55); wr(ip, 8'h55);
    chk("R4 0x87 restarts key", cfg_active, 1);
  endtask

  task automatic t_ids();
    logic [7:0] d;
    cfg_rd(8'h20, d); chk("R6 id hi", d, 8'h87);
    cfg_rd(8'h21, d); chk("R6 id lo", d, 8'hC3);
    cfg_rd(8'h22, d); chk("R6 rev", d, 8'h04);
    cfg_rd(8'h30, d); chk("R12 unlisted", d, 8'h00);
    rd(16'h0030, d);  chk("R5 other address", d, 8'hFF);
  endtask

  task automatic t_ldn();
    logic [7:0] d;
    cfg_wr(8'h07, 8'h03);
    cfg_rd(8'h07, d); chk("R7 ldn readback", d, 8'h03);
    cfg_wr(8'h64, 8'h0C);
    cfg_rd(8'h64, d); chk("R7 foreign device reads 0", d, 8'h00);
    chk("R7 foreign write ignored", flash_base, 16'h0290);
    cfg_wr(8'h07, 8'h07);
    cfg_rd(8'h64, d); chk("R7 device 7 hi", d, 8'h02);
  endtask

  task automatic t_flash();
    logic [7:0] d;
    cfg_wr(8'h64, 8'h0A); cfg_wr(8'h65, 8'h08);
    chk("R8 base", flash_base, 16'h0A08);
    chk("R9 valid", flash_base_valid, 1);
    cfg_rd(8'h65, d); chk("R8 lo readback", d, 8'h08);
    cfg_wr(8'h65, 8'h0C);
    chk("R9 unaligned", flash_base_valid, 0);
    cfg_wr(8'h64, 8'h10); cfg_wr(8'h65, 8'h00);
    chk("R9 at 0x1000", flash_base_valid, 0);
    cfg_wr(8'h64, 8'h00);
    chk("R9 zero", flash_base_valid, 0);
    cfg_wr(8'h65, 8'h08);
    chk("R9 lowest legal", flash_base_valid, 1);
  endtask

  task automatic t_steer();
    logic [7:0] d;
    cfg_wr(8'hEF, 8'hFF);
    chk("R10 sel set", flash_sel, 1);
    cfg_rd(8'hEF, d); chk("R10 readback", d, 8'h01);
    cfg_wr(8'hEF, 8'hFE);
    chk("R10 sel clear", flash_sel, 0);
    cfg_wr(8'hEF, 8'h01);
  endtask

  task automatic t_relock();
    logic [7:0] d;
    cfg_wr(8'h02, 8'h01);
    chk("R11 bit1 clear stays open", cfg_active, 1);
    cfg_wr(8'h02, 8'h02);
    chk("R11 relocked", cfg_active, 0);
    rd(ip + 16'd1, d); chk("R11 locked read", d, 8'hFF);
    wr(ip, 8'hEF); wr(ip + 16'd1, 8'h00);
    chk("R5 locked steer kept", flash_sel, 1);
    key(8'h55);
    chk("R11 new key reopens", cfg_active, 1);
  endtask

  task automatic t_alt();
    logic [7:0] d;
    do_reset(1'b1);
    key(8'h55);
    chk("R3 alt base rejects 0x55", cfg_active, 0);
    key(8'hAA);
    chk("R3 alt base key", cfg_active, 1);
    cfg_rd(8'h20, d); chk("R2 alt data port", d, 8'h87);
    rd(16'h002F, d); chk("R2 primary data port idle", d, 8'hFF);
  endtask

  initial begin
    do_reset(1'b0);
    t_reset();
    t_locked();
    t_restart();
    t_ids();
    t_ldn();
    t_flash();
    t_steer();
    t_relock();
    t_alt();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule